// File: doc/BRIEF.md
# Two-Wire Controller Command and Status Register

This block is the register-side front of a byte-oriented two-wire bus controller. The host writes a control byte and reads back a status byte. The block keeps the active-low handshake flag that paces every byte exchange. It turns start and stop commands into one-clock requests for the bit-level bus engine. From the engine's one-clock event pulses it keeps the bus status flags up to date.

The handshake flag drives three things. It drives the active-low interrupt line when interrupts are enabled. It drives a clock-stretch request while the controller is a slave. It tells the host that a byte has finished. A combined start-and-stop command in master mode asks the engine to chain a STOP, a fresh START and the address without giving up the bus. The engine supplies its current mode as a 2-bit code: 00 slave receive, 01 slave transmit, 10 master transmit, 11 master receive.

Top module: `twb_cmdstat`

## Requirements
- R1: After reset the status byte reads 8'h81 (handshake flag 1, bus-free flag 1, all else 0), irq_n and all requests are inactive, and ser_en, reg_sel, irq_en and ack_en are 0.
- R2: A control write (ctl_wr) stores bit 6 to ser_en, bits 5:4 to reg_sel, bit 3 to irq_en and bit 0 to ack_en, visible the next cycle.
- R3: A control write with bit 7 = 1 sets the handshake flag and clears the sts, ber, ad0/lrb, aas and lab status bits; it leaves the bus-free flag alone. A control write with bit 7 = 0 leaves the handshake flag unchanged.
- R4: dat_wr sets the handshake flag in modes 01 and 10. dat_rd sets it in modes 00 and 11. Neither has any effect in the other modes.
- R5: ev_byte_done or ev_misplaced clears the handshake flag (status bit 7) on the next cycle, winning over any same-cycle set.
- R6: With STA = control bit 2 and STO = bit 1, the block decodes a control write by mode. 10 in a slave mode gives req_start. 10 in mode 10 gives req_rstart. 01 in a master mode gives req_stop. 11 in a master mode gives req_chain. Each request is a single pulse in the cycle after the write; every other combination gives none.
- R7: A control write that produces req_start, req_rstart or req_chain also sets the handshake flag.
- R8: irq_n is 0 exactly while irq_en = 1 and the handshake flag is 0.
- R9: scl_hold is 1 exactly while the engine is in a slave mode (00 or 01) and the handshake flag is 0.
- R10: Status bit 3 shows the general-call flag when aas (bit 2) is 1 and the last received bit otherwise. ev_addr_hit sets aas and loads the general-call flag from ev_gen_call. ev_bit_vld loads the last received bit from ev_bit.
- R11: Bus-free flag (bit 0) goes 0 on ev_start and 1 on ev_stop. ev_misplaced sets ber (bit 4) and forces bit 0 to 1. ev_arb_lost sets lab (bit 1).
- R12: ev_stop in mode 00 sets sts (bit 5); in other modes it leaves sts unchanged.
- R13: An engine event in the same cycle as a clearing control write takes effect over the clear for the bits that event drives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Host writes the control byte |
| wdata | input | 8 | Control byte being written |
| dat_wr | input | 1 | Host writes the data register |
| dat_rd | input | 1 | Host reads the data register |
| eng_mode | input | 2 | Engine mode code |
| ev_byte_done | input | 1 | Byte plus acknowledge finished |
| ev_start | input | 1 | START seen on the bus |
| ev_stop | input | 1 | STOP seen on the bus |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_addr_hit | input | 1 | Own or general-call address received |
| ev_gen_call | input | 1 | Qualifies ev_addr_hit as general call |
| ev_misplaced | input | 1 | Misplaced START or STOP |
| ev_bit_vld | input | 1 | A received bit is valid |
| ev_bit | input | 1 | Value of the received bit |
| stat_byte | output | 8 | Status byte |
| ser_en | output | 1 | Serial interface enable |
| reg_sel | output | 2 | Register selection bits |
| irq_en | output | 1 | Interrupt enable |
| ack_en | output | 1 | Acknowledge on 9th clock when 1 |
| req_start | output | 1 | Request START plus address |
| req_rstart | output | 1 | Request repeated START |
| req_stop | output | 1 | Request STOP |
| req_chain | output | 1 | Request STOP, START plus address |
| irq_n | output | 1 | Active-low interrupt |
| scl_hold | output | 1 | Request to hold the clock low |

## Verification
The bench mixes seeded random traffic with directed sequences. It goes after same-cycle collisions. A byte-done pulse that meets a data read would leave the flag set in a design with the wrong priority, and it would miss the interrupt. An arbitration-lost pulse that meets a clearing control write would be lost by a design that clears last. It also checks commands in the wrong mode. A design that decodes STA alone in master receive would send a stray repeated START. A chained command would give a bare STOP. Data accesses in the wrong direction are checked as well; a design that sets the flag on them would release a stretched clock too early.

// File: rtl/twb_cs_pkg.sv
package twb_cs_pkg;
   typedef enum logic [1:0] {
      MD_SRX = 2'b00,
      MD_STX = 2'b01,
      MD_MTX = 2'b10,
      MD_MRX = 2'b11
   } twb_mode_e;

   localparam int CB_PIN = 7;
   localparam int CB_ESO = 6;
   localparam int CB_ES1 = 5;
   localparam int CB_ES2 = 4;
   localparam int CB_ENI = 3;
   localparam int CB_STA = 2;
   localparam int CB_STO = 1;
   localparam int CB_ACK = 0;

   typedef struct packed {
      logic sts;
      logic ber;
      logic lrb;
      logic aas;
      logic ad0;
      logic lab;
      logic bb;
   } twb_flags_t;

   typedef struct packed {
      logic start;
      logic rstart;
      logic stop;
      logic chain;
   } twb_req_t;

   function automatic logic is_master(twb_mode_e m);
      return m[1];
   endfunction

   function automatic logic is_tx(twb_mode_e m);
      return (m == MD_STX) || (m == MD_MTX);
   endfunction
endpackage

// File: rtl/twb_cmd_dec.sv
module twb_cmd_dec
   import twb_cs_pkg::*;
#(
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ctl_wr,
   input  logic      sta,
   input  logic      sto,
   input  twb_mode_e mode,
   output logic      start_cmd,
   output twb_req_t  req_q
);
   twb_req_t req_d;
   logic     chain_ok;

   generate
      if (CHAIN_EN) begin : g_chain
         assign chain_ok = 1'b1;
      end else begin : g_nochain
         assign chain_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      req_d = '0;
      if (ctl_wr) begin
         case ({sta, sto})
            2'b10: begin
               req_d.start  = !is_master(mode);
               req_d.rstart = (mode == MD_MTX);
            end
            2'b01:   req_d.stop  = is_master(mode);
            2'b11:   req_d.chain = is_master(mode) && chain_ok;
            default: req_d = '0;
         endcase
      end
   end

   assign start_cmd = req_d.start | req_d.rstart | req_d.chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_d;
   end
endmodule

// File: rtl/twb_hs_flag.sv
module twb_hs_flag
   import twb_cs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sw_set,
   input  logic      cmd_set,
   input  logic      dat_wr,
   input  logic      dat_rd,
   input  twb_mode_e mode,
   input  logic      byte_done,
   input  logic      misplaced,
   output logic      pin
);
   logic host_set;
   logic bus_clr;

   assign host_set = sw_set | cmd_set
                   | (dat_wr &&  is_tx(mode))
                   | (dat_rd && !is_tx(mode));
   assign bus_clr  = byte_done | misplaced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pin <= 1'b1;
      else if (bus_clr)  pin <= 1'b0;
      else if (host_set) pin <= 1'b1;
   end
endmodule

// File: rtl/twb_stat_flags.sv
module twb_stat_flags
   import twb_cs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_clr,
   input  twb_mode_e  mode,
   input  logic       ev_start,
   input  logic       ev_stop,
   input  logic       ev_arb_lost,
   input  logic       ev_addr_hit,
   input  logic       ev_gen_call,
   input  logic       ev_misplaced,
   input  logic       ev_bit_vld,
   input  logic       ev_bit,
   output twb_flags_t flags
);
   twb_flags_t nxt;

   always_comb begin
      nxt = flags;
      // host clear first, engine events afterwards so they win
      if (sw_clr) begin
         nxt.sts = 1'b0;
         nxt.ber = 1'b0;
         nxt.lrb = 1'b0;
         nxt.aas = 1'b0;
         nxt.ad0 = 1'b0;
         nxt.lab = 1'b0;
      end
      if (ev_start) nxt.bb = 1'b0;
      if (ev_stop) begin
         nxt.bb = 1'b1;
         if (mode == MD_SRX) nxt.sts = 1'b1;
      end
      if (ev_misplaced) begin
         nxt.ber = 1'b1;
         nxt.bb  = 1'b1;
      end
      if (ev_arb_lost) nxt.lab = 1'b1;
      if (ev_addr_hit) begin
         nxt.aas = 1'b1;
         nxt.ad0 = ev_gen_call;
      end
      if (ev_bit_vld) nxt.lrb = ev_bit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags    <= '0;
         flags.bb <= 1'b1;
      end else begin
         flags <= nxt;
      end
   end
endmodule

// File: rtl/twb_cmdstat.sv
module twb_cmdstat
   import twb_cs_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit CHAIN_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctl_wr,
   input  logic [DW-1:0] wdata,
   input  logic          dat_wr,
   input  logic          dat_rd,
   input  logic [1:0]    eng_mode,
   input  logic          ev_byte_done,
   input  logic          ev_start,
   input  logic          ev_stop,
   input  logic          ev_arb_lost,
   input  logic          ev_addr_hit,
   input  logic          ev_gen_call,
   input  logic          ev_misplaced,
   input  logic          ev_bit_vld,
   input  logic          ev_bit,
   output logic [DW-1:0] stat_byte,
   output logic          ser_en,
   output logic [1:0]    reg_sel,
   output logic          irq_en,
   output logic          ack_en,
   output logic          req_start,
   output logic          req_rstart,
   output logic          req_stop,
   output logic          req_chain,
   output logic          irq_n,
   output logic          scl_hold
);
   localparam int MSB = DW - 1;

   generate
      if (DW != 8) begin : g_bad_width
         $error("twb_cmdstat: DW must be 8");
      end
   endgenerate

   twb_mode_e  mode;
   logic       sw_set;
   logic       start_cmd;
   logic       pin;
   twb_req_t   req;
   twb_flags_t flags;

   assign mode   = twb_mode_e'(eng_mode);
   assign sw_set = ctl_wr && wdata[CB_PIN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ser_en  <= 1'b0;
         reg_sel <= 2'b00;
         irq_en  <= 1'b0;
         ack_en  <= 1'b0;
      end else if (ctl_wr) begin
         ser_en  <= wdata[CB_ESO];
         reg_sel <= {wdata[CB_ES1], wdata[CB_ES2]};
         irq_en  <= wdata[CB_ENI];
         ack_en  <= wdata[CB_ACK];
      end
   end

   twb_cmd_dec #(.CHAIN_EN(CHAIN_EN)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_wr    (ctl_wr),
      .sta       (wdata[CB_STA]),
      .sto       (wdata[CB_STO]),
      .mode      (mode),
      .start_cmd (start_cmd),
      .req_q     (req)
   );

   twb_hs_flag u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_set    (sw_set),
      .cmd_set   (start_cmd),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd),
      .mode      (mode),
      .byte_done (ev_byte_done),
      .misplaced (ev_misplaced),
      .pin       (pin)
   );

   twb_stat_flags u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .sw_clr       (sw_set),
      .mode         (mode),
      .ev_start     (ev_start),
      .ev_stop      (ev_stop),
      .ev_arb_lost  (ev_arb_lost),
      .ev_addr_hit  (ev_addr_hit),
      .ev_gen_call  (ev_gen_call),
      .ev_misplaced (ev_misplaced),
      .ev_bit_vld   (ev_bit_vld),
      .ev_bit       (ev_bit),
      .flags        (flags)
   );

   assign stat_byte[MSB] = pin;
   assign stat_byte[6]   = 1'b0;
   assign stat_byte[5]   = flags.sts;
   assign stat_byte[4]   = flags.ber;
   assign stat_byte[3]   = flags.aas ? flags.ad0 : flags.lrb;
   assign stat_byte[2]   = flags.aas;
   assign stat_byte[1]   = flags.lab;
   assign stat_byte[0]   = flags.bb;

   assign req_start  = req.start;
   assign req_rstart = req.rstart;
   assign req_stop   = req.stop;
   assign req_chain  = req.chain;

   assign irq_n    = !(irq_en && !pin);
   assign scl_hold = !pin && !is_master(mode);
endmodule

// File: rtl/twb_cmdstat_chk.sv
module twb_cmdstat_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_wr,
   input logic       ctl_pin_bit,
   input logic [1:0] eng_mode,
   input logic       ev_byte_done,
   input logic       ev_stop,
   input logic       ev_arb_lost,
   input logic       ev_addr_hit,
   input logic       ev_misplaced,
   input logic       ev_bit_vld,
   input logic [7:0] stat_byte,
   input logic       irq_en,
   input logic       irq_n,
   input logic       scl_hold,
   input logic       req_start,
   input logic       req_rstart,
   input logic       req_stop,
   input logic       req_chain
);
   logic any_req;
   logic any_ev;
   assign any_req = req_start | req_rstart | req_stop | req_chain;
   assign any_ev  = ev_byte_done | ev_stop | ev_arb_lost | ev_addr_hit
                  | ev_misplaced | ev_bit_vld;

   p_req_after_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_req |-> $past(ctl_wr));

   p_req_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_start, req_rstart, req_stop, req_chain}));

   p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_byte_done || ev_misplaced) |=> !stat_byte[7]);

   p_misplaced_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ev_misplaced |=> (stat_byte[4] && stat_byte[0]));

   p_swrst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && ctl_pin_bit && !any_ev) |=> (stat_byte[7] && stat_byte[5:1] == 5'd0));

   p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(stat_byte[7]) && irq_en) |-> !irq_n);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      scl_hold |-> !stat_byte[7]);

   p_stop_sts_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && eng_mode == 2'b00) |=> stat_byte[5]);
endmodule

bind twb_cmdstat twb_cmdstat_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_wr       (ctl_wr),
   .ctl_pin_bit  (wdata[7]),
   .eng_mode     (eng_mode),
   .ev_byte_done (ev_byte_done),
   .ev_stop      (ev_stop),
   .ev_arb_lost  (ev_arb_lost),
   .ev_addr_hit  (ev_addr_hit),
   .ev_misplaced (ev_misplaced),
   .ev_bit_vld   (ev_bit_vld),
   .stat_byte    (stat_byte),
   .irq_en       (irq_en),
   .irq_n        (irq_n),
   .scl_hold     (scl_hold),
   .req_start    (req_start),
   .req_rstart   (req_rstart),
   .req_stop     (req_stop),
   .req_chain    (req_chain)
);

// File: tb/twb_cmdstat_tb_top.sv
`timescale 1ns/1ps
module twb_cmdstat_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       dat_wr = 1'b0, dat_rd = 1'b0;
   logic [1:0] eng_mode = 2'b00;
   logic       ev_byte_done = 1'b0, ev_start = 1'b0, ev_stop = 1'b0;
   logic       ev_arb_lost = 1'b0, ev_addr_hit = 1'b0, ev_gen_call = 1'b0;
   logic       ev_misplaced = 1'b0, ev_bit_vld = 1'b0, ev_bit = 1'b0;
   logic [7:0] stat_byte;
   logic       ser_en, irq_en, ack_en, irq_n, scl_hold;
   logic [1:0] reg_sel;
   logic       req_start, req_rstart, req_stop, req_chain;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model of the register state
   logic m_pin, m_sts, m_ber, m_lrb, m_aas, m_ad0, m_lab, m_bb;
   logic m_eso, m_eni, m_ack;
   logic [1:0] m_sel;
   logic [3:0] m_req;

   always #2.5 clk = ~clk;

   twb_cmdstat dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .wdata(wdata),
      .dat_wr(dat_wr), .dat_rd(dat_rd), .eng_mode(eng_mode),
      .ev_byte_done(ev_byte_done), .ev_start(ev_start), .ev_stop(ev_stop),
      .ev_arb_lost(ev_arb_lost), .ev_addr_hit(ev_addr_hit),
      .ev_gen_call(ev_gen_call), .ev_misplaced(ev_misplaced),
      .ev_bit_vld(ev_bit_vld), .ev_bit(ev_bit), .stat_byte(stat_byte),
      .ser_en(ser_en), .reg_sel(reg_sel), .irq_en(irq_en), .ack_en(ack_en),
      .req_start(req_start), .req_rstart(req_rstart), .req_stop(req_stop),
      .req_chain(req_chain), .irq_n(irq_n), .scl_hold(scl_hold)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] exp_stat();
      return {m_pin, 1'b0, m_sts, m_ber, (m_aas ? m_ad0 : m_lrb), m_aas, m_lab, m_bb};
   endfunction

   task automatic model_reset();
      m_pin = 1'b1; m_bb = 1'b1;
      {m_sts, m_ber, m_lrb, m_aas, m_ad0, m_lab} = '0;
      {m_eso, m_eni, m_ack} = '0; m_sel = 2'b00; m_req = 4'h0;
   endtask

   // next state from the requirements, using the inputs now driven
   task automatic model_next();
      logic sw, master, sta, sto, setp;
      sw = ctl_wr && wdata[7];
      master = eng_mode[1];
      sta = wdata[2]; sto = wdata[1];
      m_req = 4'h0;
      if (ctl_wr) begin
         m_req[3] = sta && !sto && !master;              // start
         m_req[2] = sta && !sto && (eng_mode == 2'b10);   // repeated start
         m_req[1] = !sta && sto && master;                // stop
         m_req[0] = sta && sto && master;                 // chain
         m_eso = wdata[6]; m_sel = wdata[5:4]; m_eni = wdata[3]; m_ack = wdata[0];
      end
      setp = sw || m_req[3] || m_req[2] || m_req[0]
          || (dat_wr && (eng_mode == 2'b01 || eng_mode == 2'b10))
          || (dat_rd && (eng_mode == 2'b00 || eng_mode == 2'b11));
      if (ev_byte_done || ev_misplaced) m_pin = 1'b0;
      else if (setp) m_pin = 1'b1;
      if (sw) {m_sts, m_ber, m_lrb, m_aas, m_ad0, m_lab} = '0;
      if (ev_start) m_bb = 1'b0;
      if (ev_stop) begin m_bb = 1'b1; if (eng_mode == 2'b00) m_sts = 1'b1; end
      if (ev_misplaced) begin m_ber = 1'b1; m_bb = 1'b1; end
      if (ev_arb_lost) m_lab = 1'b1;
      if (ev_addr_hit) begin m_aas = 1'b1; m_ad0 = ev_gen_call; end
      if (ev_bit_vld) m_lrb = ev_bit;
   endtask

   task automatic compare_all();
      logic [7:0] es;
      es = exp_stat();
      chk("R5 flag", {7'd0, stat_byte[7]}, {7'd0, es[7]});
      chk("R12 sts", {7'd0, stat_byte[5]}, {7'd0, es[5]});
      chk("R11 ber/bb/lab", {stat_byte[6], stat_byte[4], stat_byte[1:0], 4'd0},
          {es[6], es[4], es[1:0], 4'd0});
      chk("R10 bit3/aas", {6'd0, stat_byte[3:2]}, {6'd0, es[3:2]});
      chk("R6 req", {4'd0, req_start, req_rstart, req_stop, req_chain}, {4'd0, m_req});
      chk("R2 cfg", {3'd0, ser_en, reg_sel, irq_en, ack_en}, {3'd0, m_eso, m_sel, m_eni, m_ack});
      chk("R8 irq", {7'd0, irq_n}, {7'd0, !(m_eni && !m_pin)});
      chk("R9 hold", {7'd0, scl_hold}, {7'd0, !m_pin && !eng_mode[1]});
   endtask

   // ev = {byte_done,start,stop,arb,addr,gc,mis,bitv,bit}
   task automatic step(input logic cw, input logic [7:0] wd, input logic dw, input logic dr,
                       input logic [1:0] md, input logic [8:0] ev);
      ctl_wr = cw; wdata = wd; dat_wr = dw; dat_rd = dr; eng_mode = md;
      {ev_byte_done, ev_start, ev_stop, ev_arb_lost, ev_addr_hit,
       ev_gen_call, ev_misplaced, ev_bit_vld, ev_bit} = ev;
      model_next();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input logic [1:0] md);
      step(1'b0, 8'h00, 1'b0, 1'b0, md, 9'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 status", stat_byte, 8'h81);
      chk("R1 outputs", {ser_en, reg_sel, irq_en, ack_en, irq_n,
                         req_start|req_rstart|req_stop|req_chain, 1'b0}, 8'b0000_0100);
      rst_n = 1'b1;
      idle(2'b00);

      // R2 config store
      step(1'b1, 8'h79, 1'b0, 1'b0, 2'b00, 9'd0);
      chk("R2 fields", {3'd0, ser_en, reg_sel, irq_en, ack_en}, 8'b0001_1111);
      // clear flag, then control write with bit7=0 leaves it (R3)
      step(1'b0, 8'h00, 1'b0, 1'b0, 2'b00, 9'b1_0000_0000);
      chk("R8 irq low", {7'd0, irq_n}, 8'd0);
      step(1'b1, 8'h08, 1'b0, 1'b0, 2'b10, 9'd0);
      chk("R3 pin0 write", {7'd0, stat_byte[7]}, 8'd0);
      // R4: data write in receive mode has no effect, read in transmit neither
      step(1'b0, 8'h00, 1'b1, 1'b0, 2'b11, 9'd0);
      chk("R4 wr in rx", {7'd0, stat_byte[7]}, 8'd0);
      step(1'b0, 8'h00, 1'b0, 1'b1, 2'b01, 9'd0);
      chk("R4 rd in tx", {7'd0, stat_byte[7]}, 8'd0);
      chk("R9 hold slave", {7'd0, scl_hold}, 8'd1);
      step(1'b0, 8'h00, 1'b0, 1'b1, 2'b00, 9'd0);
      chk("R4 rd in rx", {7'd0, stat_byte[7]}, 8'd1);
      // R5: read and byte-done together: clear wins
      step(1'b0, 8'h00, 1'b0, 1'b1, 2'b00, 9'b1_0000_0000);
      chk("R5 priority", {7'd0, stat_byte[7]}, 8'd0);
      // R7/R6: start command from slave mode
      step(1'b1, 8'h4C, 1'b0, 1'b0, 2'b00, 9'd0);
      chk("R7 start sets flag", {7'd0, stat_byte[7]}, 8'd1);
      chk("R6 start pulse", {4'd0, req_start, req_rstart, req_stop, req_chain}, 8'b1000);
      idle(2'b10);
      chk("R6 one pulse", {4'd0, req_start, req_rstart, req_stop, req_chain}, 8'd0);
      // R6 chain in master transmit, R6 start in master receive is a no-op
      step(1'b1, 8'h46, 1'b0, 1'b0, 2'b10, 9'd0);
      chk("R6 chain", {4'd0, req_start, req_rstart, req_stop, req_chain}, 8'b0001);
      step(1'b1, 8'h44, 1'b0, 1'b0, 2'b11, 9'd0);
      chk("R6 sta in mrx", {4'd0, req_start, req_rstart, req_stop, req_chain}, 8'd0);
      // R10/R11/R13: flags, then clear with same-cycle arbitration loss
      step(1'b0, 8'h00, 1'b0, 1'b0, 2'b00, 9'b0_1001_1000);
      chk("R10 gc", {6'd0, stat_byte[3:2]}, 8'b11);
      chk("R11 bb busy", {7'd0, stat_byte[0]}, 8'd0);
      step(1'b1, 8'h80, 1'b0, 1'b0, 2'b00, 9'b0_0010_0000);
      chk("R13 lab kept", stat_byte, 8'h82);
      step(1'b0, 8'h00, 1'b0, 1'b0, 2'b00, 9'b0_0100_0000);
      chk("R12 sts", {7'd0, stat_byte[5]}, 8'd1);
      step(1'b0, 8'h00, 1'b0, 1'b0, 2'b00, 9'b0_0000_0100);
      chk("R11 misplaced", {3'd0, stat_byte[4], 3'd0, stat_byte[0]}, 8'b0001_0001);

      // seeded random traffic
      for (int i = 0; i < 3000; i++) begin
         logic [8:0] ev;
         ev = '0;
         for (int b = 0; b < 9; b++) ev[b] = (($urandom % 8) == 0);
         step(($urandom % 4) == 0, 8'($urandom), ($urandom % 5) == 0,
              ($urandom % 5) == 0, 2'($urandom), ev);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule